// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block sits behind the control pins of a double-data-rate SDRAM device model or controller shadow. On every rising clock edge it samples chip select, the three command strobes, clock enable, a 2-bit bank address and a 13-bit address bus. It turns those pins into a decoded command code and keeps, for each of four banks, whether a row is open and which row it is.

Several commands also read the address bus, and the block resolves those fields. Bit 10 selects between precharging one bank and precharging all of them, and on read or write it carries the auto-precharge request. On a mode-register load, the bank address picks the base register or the extended register. When clock enable is low the block does not decode commands. Instead it reports one of two power-down flavours: precharge power-down if no row is open, active power-down otherwise. All outputs are registered and reflect the pins sampled at the previous rising edge.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: With cke high and cs_n sampled high, the edge decodes as no-operation (cmd=0) and no bank, row or mode state changes.
- R2: With cke high and cs_n low, {ras_n,cas_n,we_n} decodes as 011 activate (cmd=1), 101 read (cmd=2), 100 write (cmd=3), 010 precharge (cmd=4), 001 refresh (cmd=5), 000 mode load (cmd=6). 111 and 110 give cmd=0. The code appears on cmd one edge after sampling and lasts one cycle.
- R3: Activate sets bit ba of bank_open and stores addr in open_rows[ba*13 +: 13].
- R4: Precharge with addr[10]=0 clears only bank ba. With addr[10]=1 it clears all four banks.
- R5: Read or write to an open bank pulses auto_pre equal to addr[10]. When addr[10]=1 that bank is idle afterwards.
- R6: Read or write to an idle bank pulses illegal and reports cmd=0. auto_pre stays 0 and no bank state changes.
- R7: Mode load with ba[0]=0 stores addr into base_mode. With ba[0]=1 it stores addr into ext_mode. mrs_ext holds ba[0] of the most recent mode load.
- R8: An edge with cke low decodes nothing and changes no state. pwr_state becomes 1 (precharge power-down) if all banks are idle and 2 (active power-down) if any is open. An edge with cke high sets pwr_state to 0.
- R9: While rst_n is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge samples all inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| addr | input | 13 | Row, column/flag or opcode field |
| cmd | output | 3 | Decoded command code |
| bank_open | output | 4 | One bit per bank, 1 = row open |
| open_rows | output | 52 | Open row per bank, bank b at b*13 |
| auto_pre | output | 1 | Auto-precharge request of the accepted read/write |
| illegal | output | 1 | Read/write aimed at an idle bank |
| mrs_ext | output | 1 | Register targeted by the last mode load |
| base_mode | output | 13 | Base mode register contents |
| ext_mode | output | 13 | Extended mode register contents |
| pwr_state | output | 2 | 0 running, 1 precharge power-down, 2 active power-down |

## Verification
The interesting overlap is a command on the strobes in the same cycle that clock enable drops. Two cases show it. In the first, an activate is driven with cke low on an all-idle device; the bench expects precharge power-down and no open bank. In the second, a precharge-all is driven with cke low while rows are open; the bench expects active power-down with every row still open. A second overlap is a read with auto-precharge: it pulses auto_pre and closes its bank in the same cycle, and a following read to that bank must then be flagged illegal. A behavioural model predicts every output on every clock, and the bench compares against it during both directed and pseudo-random stimulus.

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker #(
  parameter int ROW_W  = 13,
  parameter int BA_W   = 2,
  parameter int AP_BIT = 10
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cke,
  input  logic                          cs_n,
  input  logic                          ras_n,
  input  logic                          cas_n,
  input  logic                          we_n,
  input  logic [BA_W-1:0]               ba,
  input  logic [ROW_W-1:0]              addr,
  output logic [2:0]                    cmd,
  output logic [(1<<BA_W)-1:0]          bank_open,
  output logic [(1<<BA_W)*ROW_W-1:0]    open_rows,
  output logic                          auto_pre,
  output logic                          illegal,
  output logic                          mrs_ext,
  output logic [ROW_W-1:0]              base_mode,
  output logic [ROW_W-1:0]              ext_mode,
  output logic [1:0]                    pwr_state
);
  localparam int NB = 1 << BA_W;
  localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2, C_WR = 3'd3,
                         C_PRE = 3'd4, C_REF = 3'd5, C_MRS = 3'd6;
  localparam logic [1:0] P_RUN = 2'd0, P_PPD = 2'd1, P_APD = 2'd2;

  logic [ROW_W-1:0] rows [NB];
  logic [2:0] pins;
  logic live, hit, ap;

  assign pins = {ras_n, cas_n, we_n};
  assign live = cke & ~cs_n;
  assign hit  = bank_open[ba];
  assign ap   = addr[AP_BIT];

  for (genvar b = 0; b < NB; b++) begin : g_rows
    assign open_rows[b*ROW_W +: ROW_W] = rows[b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd       <= C_NOP;
      bank_open <= '0;
      auto_pre  <= 1'b0;
      illegal   <= 1'b0;
      mrs_ext   <= 1'b0;
      base_mode <= '0;
      ext_mode  <= '0;
      pwr_state <= P_RUN;
      for (int b = 0; b < NB; b++) rows[b] <= '0;
    end else begin
      cmd      <= C_NOP;
      auto_pre <= 1'b0;
      illegal  <= 1'b0;
      pwr_state <= cke ? P_RUN : (|bank_open ? P_APD : P_PPD);
      if (live) begin
        unique case (pins)
          3'b011: begin
            cmd           <= C_ACT;
            bank_open[ba] <= 1'b1;
            rows[ba]      <= addr;
          end
          3'b101, 3'b100: begin
            if (hit) begin
              cmd      <= pins[0] ? C_RD : C_WR;
              auto_pre <= ap;
              if (ap) bank_open[ba] <= 1'b0;
            end else begin
              illegal <= 1'b1;
            end
          end
          3'b010: begin
            cmd <= C_PRE;
            if (ap) bank_open <= '0;
            else    bank_open[ba] <= 1'b0;
          end
          3'b001: cmd <= C_REF;
          3'b000: begin
            cmd     <= C_MRS;
            mrs_ext <= ba[0];
            if (ba[0]) ext_mode  <= addr;
            else       base_mode <= addr;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/sdram_cmd_tracker_chk.sv
module sdram_cmd_tracker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cke,
  input logic       cs_n,
  input logic [2:0] cmd,
  input logic [3:0] bank_open,
  input logic       auto_pre,
  input logic       illegal,
  input logic [1:0] pwr_state
);
  // R1
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && cke) |=> (cmd == 3'd0 && bank_open == $past(bank_open)));
  // R3
  act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd1) |-> (bank_open != 4'd0));
  // R5
  ap_only_rw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    auto_pre |-> (cmd == 3'd2 || cmd == 3'd3));
  // R6
  illegal_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (cmd == 3'd0 && !auto_pre && $stable(bank_open)));
  // R8
  ppd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'd1) |-> (bank_open == 4'd0));
  // R8
  apd_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'd2) |-> (bank_open != 4'd0 && cmd == 3'd0));
  // R8
  pd_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> $stable(bank_open));
endmodule

bind sdram_cmd_tracker sdram_cmd_tracker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .cmd(cmd),
  .bank_open(bank_open), .auto_pre(auto_pre), .illegal(illegal),
  .pwr_state(pwr_state)
);

// File: tb/sdram_cmd_tracker_tb.sv
module sdram_cmd_tracker_tb;
  logic clk = 0, rst_n = 0;
  logic cke = 1, cs_n = 1, ras_n = 1, cas_n = 1, we_n = 1;
  logic [1:0] ba = 0;
  logic [12:0] addr = 0;
  logic [2:0] cmd;
  logic [3:0] bank_open;
  logic [51:0] open_rows;
  logic auto_pre, illegal, mrs_ext;
  logic [12:0] base_mode, ext_mode;
  logic [1:0] pwr_state;

  int total = 0, bad = 0;
  bit done = 0;

  bit m_open [4];
  int m_row [4];
  int m_cmd, m_ap, m_ill, m_sel, m_base, m_ext, m_pwr;

  always #4 clk = ~clk;

  sdram_cmd_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .cmd(cmd),
    .bank_open(bank_open), .open_rows(open_rows), .auto_pre(auto_pre),
    .illegal(illegal), .mrs_ext(mrs_ext), .base_mode(base_mode),
    .ext_mode(ext_mode), .pwr_state(pwr_state)
  );

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int b = 0; b < 4; b++) begin m_open[b] = 0; m_row[b] = 0; end
    m_cmd = 0; m_ap = 0; m_ill = 0; m_sel = 0; m_base = 0; m_ext = 0; m_pwr = 0;
  endtask

  task automatic model_edge(bit k, bit c, bit [2:0] p, int bb, int a);
    bit any = 0;
    bit a10 = a[10];
    for (int b = 0; b < 4; b++) any |= m_open[b];
    m_cmd = 0; m_ap = 0; m_ill = 0;
    m_pwr = k ? 0 : (any ? 2 : 1);
    if (k && !c) begin
      if (p == 3'b011) begin m_cmd = 1; m_open[bb] = 1; m_row[bb] = a; end
      else if (p == 3'b101 || p == 3'b100) begin
        if (m_open[bb]) begin
          m_cmd = (p == 3'b101) ? 2 : 3;
          m_ap = a10;
          if (a10) m_open[bb] = 0;
        end else m_ill = 1;
      end
      else if (p == 3'b010) begin
        m_cmd = 4;
        if (a10) for (int b = 0; b < 4; b++) m_open[b] = 0;
        else m_open[bb] = 0;
      end
      else if (p == 3'b001) m_cmd = 5;
      else if (p == 3'b000) begin
        m_cmd = 6; m_sel = bb % 2;
        if (bb % 2) m_ext = a; else m_base = a;
      end
    end
  endtask

  task automatic compare(string req);
    int ob = 0;
    for (int b = 0; b < 4; b++) ob |= int'(m_open[b]) << b;
    chk(req, "cmd", cmd, m_cmd);
    chk(req, "bank_open", bank_open, ob);
    for (int b = 0; b < 4; b++)
      chk(req, "open_row", open_rows[b*13 +: 13], m_row[b]);
    chk(req, "auto_pre", auto_pre, m_ap);
    chk(req, "illegal", illegal, m_ill);
    chk(req, "mrs_ext", mrs_ext, m_sel);
    chk(req, "base_mode", base_mode, m_base);
    chk(req, "ext_mode", ext_mode, m_ext);
    chk(req, "pwr_state", pwr_state, m_pwr);
  endtask

  task automatic step(string req, bit k, bit c, bit [2:0] p, int bb, int a);
    cke = k; cs_n = c; {ras_n, cas_n, we_n} = p; ba = bb[1:0]; addr = a[12:0];
    @(posedge clk);
    model_edge(k, c, p, bb, a);
    #1;
    compare(req);
  endtask

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1 compare("R9");
    rst_n = 1;
    // R2 decode and R3 activate
    step("R3", 1, 0, 3'b011, 0, 13'h0123);
    step("R3", 1, 0, 3'b011, 2, 13'h1abc);
    step("R2", 1, 0, 3'b111, 1, 0);
    step("R2", 1, 0, 3'b110, 1, 0);
    step("R2", 1, 0, 3'b001, 0, 0);
    // R1 deselect: activate pattern with cs high
    step("R1", 1, 1, 3'b011, 1, 13'h0fff);
    step("R1", 1, 1, 3'b010, 0, 13'h0400);
    // R5 read/write without and with auto-precharge
    step("R5", 1, 0, 3'b101, 0, 13'h0010);
    step("R5", 1, 0, 3'b100, 2, 13'h0020);
    step("R5", 1, 0, 3'b101, 2, 13'h0420);
    // R6 access to now idle bank 2 and never-opened bank 3
    step("R6", 1, 0, 3'b100, 2, 13'h0400);
    step("R6", 1, 0, 3'b101, 3, 0);
    // R4 single and all precharge
    step("R3", 1, 0, 3'b011, 1, 13'h0555);
    step("R3", 1, 0, 3'b011, 3, 13'h0aaa);
    step("R4", 1, 0, 3'b010, 1, 13'h0000);
    step("R4", 1, 0, 3'b010, 2, 13'h1bff);
    step("R4", 1, 0, 3'b010, 0, 13'h0400);
    // R7 mode loads
    step("R7", 1, 0, 3'b000, 0, 13'h0032);
    step("R7", 1, 0, 3'b000, 1, 13'h0002);
    step("R7", 1, 0, 3'b000, 2, 13'h0061);
    // R8 cke low on idle device with activate on the pins
    step("R8", 0, 0, 3'b011, 0, 13'h0777);
    step("R8", 0, 0, 3'b000, 1, 13'h1111);
    step("R8", 1, 0, 3'b011, 1, 13'h0222);
    step("R8", 0, 0, 3'b010, 0, 13'h0400);
    step("R8", 0, 1, 3'b111, 0, 0);
    step("R8", 1, 0, 3'b111, 0, 0);
    // mixed pseudo-random traffic
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom;
      step("R2", (r % 8) != 0, (r[5:3] == 0), r[8:6], r[10:9], r[23:11]);
    end
    // R9 reset in the middle of traffic
    step("R3", 1, 0, 3'b011, 3, 13'h0099);
    rst_n = 0; #1;
    model_reset();
    compare("R9");
    @(posedge clk); #1 rst_n = 1;
    step("R9", 1, 0, 3'b111, 0, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule